// File: doc/BRIEF.md
# UART FIFO status and interrupt unit

This unit holds the receive and transmit byte queues of a serial port and produces three things from them: a status word, a sticky interrupt-cause register and a single interrupt line. The deserializer pushes received bytes in, and a register read pops them out. Register writes push bytes for transmission, and the serializer pops them. The status word is rebuilt every cycle from the two occupancy counts and the two trigger levels. Each asserted low status bit, along with the transmit trigger, the overrun events and the receive timeout, is latched into the cause register. A cause stays set until software writes a one to that bit.

The channel mode decides which queue limits the receiver's acceptance. The receiver can only take a byte while the relevant queue has space. A counter of character-time ticks raises a receive timeout cause once the line has been quiet for a set number of characters after the last received byte. The bit serializers, the baud generator and the bus decoding are outside the unit. Read and write strobes arrive as plain ports.

Top module: `uart_fifo_irq_unit`

## Requirements
- R1: Receive status bits follow the RX count each cycle:
  - status bit 0 is set when the count is at least `rx_trig_lvl`;
  - status bit 1 is set when the count is zero;
  - status bit 2 is set when the count equals the depth (64).
- R2: Transmit status bits follow the TX count each cycle:
  - status bit 3 is set when the count is zero;
  - status bit 4 is set when the count equals the depth;
  - status bit 13 is set when the count is at least `tx_trig_lvl`.
  - All other status bits read zero.
- R3: On every clock edge, each set status bit among bits 4..0 sets the same bit of `isr`. Status bit 13 sets `isr` bit 10. An `isr` bit stays set until it is cleared.
- R4: A cycle with `isr_clr_wr` high clears every `isr` bit for which `isr_clr_bits` is one. If a cause for that bit is present in the same cycle, the bit stays set.
- R5: `irq` is high exactly when some bit of `irq_mask & isr` is one.
- R6: A receive push while the RX queue holds 64 bytes stores nothing, leaves the count unchanged and sets `isr` bit 5.
- R7: A transmit push while the TX queue holds 64 bytes stores nothing and sets `isr` bit 12.
- R8: A transmit push is ignored when `tx_enable` is 0 or `tx_disable` is 1.
- R9: Both queues deliver bytes in arrival order on their head outputs. A queue's head reads zero while it is empty. A pop of an empty queue has no effect.
- R10: `rx_ready` depends on `chan_mode`:
  - mode 0 (normal): high while the RX queue is not full;
  - mode 1 (echo): high while neither queue is full;
  - mode 2 (local loopback): always high;
  - mode 3 (remote loopback): high while the TX queue is not full.
- R11: After the most recent receive push, the fourth `char_tick` with no further push sets `isr` bit 8, and it does so only once. A receive push restarts the count.
- R12: While reset is asserted, both counts are zero and `isr` is zero. The status word therefore shows both empty bits, plus the trigger bits that the trigger levels imply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Receiver may deliver a byte (mode dependent) |
| rx_pop | input | 1 | Receive data register read strobe |
| rx_head | output | 8 | Oldest received byte, zero when empty |
| tx_push | input | 1 | Transmit data register write strobe |
| tx_byte | input | 8 | Byte written for transmission |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_head | output | 8 | Oldest transmit byte, zero when empty |
| tx_enable | input | 1 | Transmit enable control bit |
| tx_disable | input | 1 | Transmit disable control bit |
| chan_mode | input | 2 | 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| rx_trig_lvl | input | 7 | Receive trigger level |
| tx_trig_lvl | input | 7 | Transmit trigger level |
| char_tick | input | 1 | One pulse per character time |
| isr_clr_wr | input | 1 | Write-one-to-clear strobe for `isr` |
| isr_clr_bits | input | 13 | Bits of `isr` to clear |
| irq_mask | input | 13 | Interrupt enable mask |
| status | output | 14 | Live status word |
| isr | output | 13 | Sticky interrupt causes |
| irq | output | 1 | Interrupt line |

## Verification
The clear strobe and a new cause can land on the same edge. The bench provokes this right after reset: both queues are empty, so the empty status bits are still asserted while ones are written to every `isr` bit. The judgement is that those bits survive the write. In a later cycle the cause behind bit 1 is removed by a received byte, and the same kind of write then clears bit 1. The receive timeout counter also meets a new push in a tick window, and the bench checks that the push restarts the count rather than letting the earlier byte's timeout fire.

// File: rtl/ufsi_pkg.sv
package ufsi_pkg;
   localparam int ST_W      = 14;
   localparam int IS_W      = 13;
   localparam int ST_RTRIG  = 0;
   localparam int ST_REMPTY = 1;
   localparam int ST_RFULL  = 2;
   localparam int ST_TEMPTY = 3;
   localparam int ST_TFULL  = 4;
   localparam int ST_TTRIG  = 13;
   localparam int IS_ROVR   = 5;
   localparam int IS_TOUT   = 8;
   localparam int IS_TTRIG  = 10;
   localparam int IS_TOVR   = 12;

   typedef enum logic [1:0] {
      CM_NORMAL    = 2'd0,
      CM_ECHO      = 2'd1,
      CM_LOCAL_LB  = 2'd2,
      CM_REMOTE_LB = 2'd3
   } chan_mode_e;
endpackage

// File: rtl/ufsi_byte_fifo.sv
module ufsi_byte_fifo #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [CW-1:0] count,
   output logic [DW-1:0] head,
   output logic          drop
);
   initial begin : chk_params
      assert (DEPTH >= 2) else $fatal(1, "ufsi_byte_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_idx;
   logic [AW-1:0] rd_idx;
   logic [CW-1:0] cnt;
   logic          full, empty, do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign drop    = push & full;
   assign count   = cnt;

   // read index is the write index stepped back by the occupancy
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign rd_idx = wr_idx - AW'(cnt);
      end else begin : g_mod
         logic [CW:0] sum;
         assign sum    = (CW+1)'(wr_idx) + (CW+1)'(DEPTH) - (CW+1)'(cnt);
         assign rd_idx = (sum >= (CW+1)'(DEPTH)) ? AW'(sum - (CW+1)'(DEPTH)) : AW'(sum);
      end
   endgenerate

   assign head = empty ? '0 : mem[rd_idx];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_idx] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_idx <= (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == CW'(DEPTH)));
   p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/ufsi_rx_timeout.sv
module ufsi_rx_timeout #(
   parameter int TOUT_CHARS = 4,
   localparam int TW        = $clog2(TOUT_CHARS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_seen,
   input  logic tick,
   output logic fire
);
   initial begin : chk_params
      assert (TOUT_CHARS >= 1) else $fatal(1, "ufsi_rx_timeout: TOUT_CHARS must be at least 1");
   end

   logic          armed;
   logic [TW-1:0] ticks;

   assign fire = armed & tick & ~rx_seen & (ticks == TW'(TOUT_CHARS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         ticks <= '0;
      end else if (rx_seen) begin
         armed <= 1'b1;
         ticks <= '0;
      end else if (fire) begin
         armed <= 1'b0;
         ticks <= '0;
      end else if (armed && tick) begin
         ticks <= ticks + 1'b1;
      end
   end

   p_tout_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   p_tout_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_seen |=> !fire);
endmodule

// File: rtl/ufsi_stat_irq.sv
module ufsi_stat_irq
   import ufsi_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   rx_cnt,
   input  logic [CW-1:0]   tx_cnt,
   input  logic [CW-1:0]   rx_trig,
   input  logic [CW-1:0]   tx_trig,
   input  logic            rx_drop,
   input  logic            tx_drop,
   input  logic            tout,
   input  logic            clr_wr,
   input  logic [IS_W-1:0] clr_bits,
   input  logic [IS_W-1:0] mask,
   output logic [ST_W-1:0] status,
   output logic [IS_W-1:0] isr,
   output logic            irq
);
   logic [IS_W-1:0] set_v, clr_v, isr_q;

   always_comb begin
      status            = '0;
      status[ST_RTRIG]  = (rx_cnt >= rx_trig);
      status[ST_REMPTY] = (rx_cnt == '0);
      status[ST_RFULL]  = (rx_cnt == CW'(DEPTH));
      status[ST_TEMPTY] = (tx_cnt == '0);
      status[ST_TFULL]  = (tx_cnt == CW'(DEPTH));
      status[ST_TTRIG]  = (tx_cnt >= tx_trig);
   end

   always_comb begin
      set_v           = '0;
      set_v[4:0]      = status[4:0];
      set_v[IS_TTRIG] = status[ST_TTRIG];
      set_v[IS_ROVR]  = rx_drop;
      set_v[IS_TOVR]  = tx_drop;
      set_v[IS_TOUT]  = tout;
      clr_v           = clr_wr ? clr_bits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_v) | set_v;
   end

   assign isr = isr_q;
   assign irq = |(mask & isr_q);

   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((isr_q & $past(isr_q)) == $past(isr_q)));
   p_ttrig_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_TTRIG] |=> isr_q[IS_TTRIG]);
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((isr_q & $past(set_v)) == $past(set_v)));
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((isr_q & $past(clr_bits & ~set_v)) == '0));
endmodule

// File: rtl/uart_fifo_irq_unit.sv
module uart_fifo_irq_unit
   import ufsi_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter int DW         = 8,
   parameter int TOUT_CHARS = 4,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_push,
   input  logic [DW-1:0]   rx_byte,
   output logic            rx_ready,
   input  logic            rx_pop,
   output logic [DW-1:0]   rx_head,
   input  logic            tx_push,
   input  logic [DW-1:0]   tx_byte,
   input  logic            tx_pop,
   output logic [DW-1:0]   tx_head,
   input  logic            tx_enable,
   input  logic            tx_disable,
   input  logic [1:0]      chan_mode,
   input  logic [CW-1:0]   rx_trig_lvl,
   input  logic [CW-1:0]   tx_trig_lvl,
   input  logic            char_tick,
   input  logic            isr_clr_wr,
   input  logic [IS_W-1:0] isr_clr_bits,
   input  logic [IS_W-1:0] irq_mask,
   output logic [ST_W-1:0] status,
   output logic [IS_W-1:0] isr,
   output logic            irq
);
   logic [CW-1:0] rx_cnt, tx_cnt;
   logic          rx_drop, tx_drop, tx_push_ok, tout_fire;
   logic          rx_room, tx_room;

   assign tx_push_ok = tx_push & tx_enable & ~tx_disable;
   assign rx_room    = (rx_cnt != CW'(DEPTH));
   assign tx_room    = (tx_cnt != CW'(DEPTH));

   always_comb begin
      case (chan_mode_e'(chan_mode))
         CM_NORMAL:    rx_ready = rx_room;
         CM_ECHO:      rx_ready = rx_room & tx_room;
         CM_LOCAL_LB:  rx_ready = 1'b1;
         CM_REMOTE_LB: rx_ready = tx_room;
         default:      rx_ready = 1'b0;
      endcase
   end

   ufsi_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_byte),
      .pop(rx_pop), .count(rx_cnt), .head(rx_head), .drop(rx_drop));

   ufsi_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push_ok), .push_data(tx_byte),
      .pop(tx_pop), .count(tx_cnt), .head(tx_head), .drop(tx_drop));

   ufsi_rx_timeout #(.TOUT_CHARS(TOUT_CHARS)) u_tout (
      .clk(clk), .rst_n(rst_n), .rx_seen(rx_push), .tick(char_tick), .fire(tout_fire));

   ufsi_stat_irq #(.DEPTH(DEPTH)) u_stat (
      .clk(clk), .rst_n(rst_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
      .rx_trig(rx_trig_lvl), .tx_trig(tx_trig_lvl), .rx_drop(rx_drop),
      .tx_drop(tx_drop), .tout(tout_fire), .clr_wr(isr_clr_wr),
      .clr_bits(isr_clr_bits), .mask(irq_mask), .status(status), .isr(isr), .irq(irq));

   p_rx_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |=> isr[IS_ROVR]);
   p_tx_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drop |=> isr[IS_TOVR]);
   p_tx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && (!tx_enable || tx_disable) && !tx_pop) |=> $stable(tx_cnt));
endmodule

// File: tb/sim_uart_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_uart_fifo_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
   logic [7:0]  rx_byte = '0, tx_byte = '0;
   logic        tx_enable = 1'b1, tx_disable = 1'b0;
   logic [1:0]  chan_mode = 2'd0;
   logic [6:0]  rx_trig_lvl = 7'd2, tx_trig_lvl = 7'd2;
   logic        char_tick = 1'b0, isr_clr_wr = 1'b0;
   logic [12:0] isr_clr_bits = '0, irq_mask = 13'h1FFF;
   logic        rx_ready, irq;
   logic [7:0]  rx_head, tx_head;
   logic [13:0] status;
   logic [12:0] isr;
   int          checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   uart_fifo_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte), .rx_ready(rx_ready),
      .rx_pop(rx_pop), .rx_head(rx_head), .tx_push(tx_push), .tx_byte(tx_byte),
      .tx_pop(tx_pop), .tx_head(tx_head), .tx_enable(tx_enable), .tx_disable(tx_disable),
      .chan_mode(chan_mode), .rx_trig_lvl(rx_trig_lvl), .tx_trig_lvl(tx_trig_lvl),
      .char_tick(char_tick), .isr_clr_wr(isr_clr_wr), .isr_clr_bits(isr_clr_bits),
      .irq_mask(irq_mask), .status(status), .isr(isr), .irq(irq));

   // {mode[1:0], fill rx, fill tx, expected rx_ready}
   localparam logic [4:0] MODE_VEC [8] = '{
      5'b00_0_0_1, 5'b00_1_0_0, 5'b01_0_1_0, 5'b01_1_0_0,
      5'b01_0_0_1, 5'b10_1_1_1, 5'b11_1_0_1, 5'b11_0_1_0 };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_rx(input logic [7:0] b);
      rx_push = 1'b1; rx_byte = b; @(negedge clk); rx_push = 1'b0;
   endtask
   task automatic push_tx(input logic [7:0] b);
      tx_push = 1'b1; tx_byte = b; @(negedge clk); tx_push = 1'b0;
   endtask
   task automatic pop_rx();
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
   endtask
   task automatic pop_tx();
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
   endtask
   task automatic tick();
      char_tick = 1'b1; @(negedge clk); char_tick = 1'b0;
   endtask
   task automatic clr(input logic [12:0] bits);
      isr_clr_wr = 1'b1; isr_clr_bits = bits; @(negedge clk); isr_clr_wr = 1'b0;
   endtask
   task automatic reset_dut();
      rst_n = 1'b0; chan_mode = 2'd0; tx_enable = 1'b1; tx_disable = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; @(negedge clk);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin : main
      // reset state (R12)
      repeat (3) @(negedge clk);
      chk("R12 status in reset", 32'(status), 32'h000A);
      chk("R12 isr in reset", 32'(isr), 32'h0);
      chk("R12 irq in reset", 32'(irq), 32'h0);
      chk("R12 rx head in reset", 32'(rx_head), 32'h0);

      // table walk: accept capacity by channel mode (R10)
      for (int i = 0; i < 8; i++) begin
         reset_dut();
         if (MODE_VEC[i][2]) for (int k = 0; k < 64; k++) push_rx(8'(k));
         if (MODE_VEC[i][1]) for (int k = 0; k < 64; k++) push_tx(8'(k));
         chan_mode = MODE_VEC[i][4:3];
         @(negedge clk);
         chk($sformatf("R10 rx_ready row %0d", i), 32'(rx_ready), 32'(MODE_VEC[i][0]));
      end

      // sticky latch, irq, set-wins clear
      reset_dut();
      chk("R3 empties latched", 32'(isr), 32'h000A);
      chk("R5 irq with mask", 32'(irq), 32'h1);
      irq_mask = 13'h0; @(negedge clk);
      chk("R5 irq masked off", 32'(irq), 32'h0);
      clr(13'h1FFF);
      chk("R4 set wins over clear", 32'(isr), 32'h000A);
      push_rx(8'hA1);
      chk("R1 one byte status", 32'(status), 32'h0008);
      push_rx(8'hB2);
      chk("R1 trigger reached", 32'(status), 32'h0009);
      clr(13'h0002);
      chk("R4 clear without cause", 32'(isr), 32'h0009);
      push_rx(8'hC3);
      chk("R9 order 1", 32'(rx_head), 32'hA1);
      pop_rx();
      chk("R9 order 2", 32'(rx_head), 32'hB2);
      pop_rx();
      chk("R9 order 3", 32'(rx_head), 32'hC3);
      pop_rx();
      chk("R9 empty head zero", 32'(rx_head), 32'h0);
      pop_rx();
      chk("R9 empty pop no effect", 32'(status), 32'h000A);

      // transmit gating, trigger remap, overflow
      tx_enable = 1'b0; push_tx(8'h55);
      chk("R8 push with enable low", 32'(status[3]), 32'h1);
      tx_enable = 1'b1; tx_disable = 1'b1; push_tx(8'h66);
      chk("R8 push with disable high", 32'(status[3]), 32'h1);
      tx_disable = 1'b0;
      push_tx(8'h11); push_tx(8'h22);
      chk("R2 tx status with trigger", 32'(status), 32'h2002);
      @(negedge clk);
      chk("R3 ttrig latched at bit 10", 32'(isr[10]), 32'h1);
      chk("R9 tx order 1", 32'(tx_head), 32'h11);
      pop_tx();
      chk("R9 tx order 2", 32'(tx_head), 32'h22);
      for (int k = 0; k < 63; k++) push_tx(8'(k));
      chk("R2 tx full", 32'(status[4]), 32'h1);
      chk("R7 no overrun yet", 32'(isr[12]), 32'h0);
      push_tx(8'hEE);
      chk("R7 overrun latched", 32'(isr[12]), 32'h1);
      chk("R7 head unchanged", 32'(tx_head), 32'h22);

      // receive overflow
      reset_dut();
      for (int k = 0; k < 64; k++) push_rx(8'(k));
      chk("R1 rx full", 32'(status[2:0]), 32'h5);
      push_rx(8'hFF);
      chk("R6 overrun latched", 32'(isr[5]), 32'h1);
      for (int k = 0; k < 63; k++) pop_rx();
      chk("R6 dropped byte not stored", 32'(rx_head), 32'd63);

      // receive timeout
      reset_dut();
      push_rx(8'h5A);
      repeat (3) tick();
      chk("R11 no timeout after three", 32'(isr[8]), 32'h0);
      tick();
      chk("R11 timeout after four", 32'(isr[8]), 32'h1);
      irq_mask = 13'h100; @(negedge clk);
      chk("R5 irq from timeout", 32'(irq), 32'h1);
      clr(13'h0100);
      chk("R4 timeout cleared", 32'(isr[8]), 32'h0);
      chk("R5 irq drops after clear", 32'(irq), 32'h0);
      repeat (5) tick();
      chk("R11 timeout only once", 32'(isr[8]), 32'h0);
      push_rx(8'h01); repeat (3) tick();
      push_rx(8'h02); repeat (3) tick();
      chk("R11 push restarts count", 32'(isr[8]), 32'h0);
      tick();
      chk("R11 timeout after restart", 32'(isr[8]), 32'h1);

      summary();
   end
endmodule